// File: doc/BRIEF.md
# Clock Source Lock and Slip Monitor

This block gathers the lock state and the slip errors of eleven external sample-clock sources and presents them in two status words that a register file can return to a host. The extended status word holds one live lock flag per source in its low half and one sticky slip flag per source in its high half. The current status word shows whether the source chosen by the clock selection code is locked, together with the nominal sample-rate code.

The lock flags follow the inputs, delayed by one register stage. The slip flags remember any error pulse until the host fetches the extended status word with a single-quadlet read. A block read of the same word leaves the flags alone. Two single-cycle event pulses go to a notification unit. One fires on any change in the lock flags. The other fires when the lock indication of the selected source changes. Slip activity never produces an event.

Top module: `clksrc_lock_monitor`

## Requirements
- R1: One clock edge after the inputs are sampled, `ext_status` bits 10:0 equal `src_lock`. The bit order is AES1, AES2, AES3, AES4, ADAT, TDIF, ARX1, ARX2, ARX3, ARX4, word clock, with bit 0 first.
- R2: `ext_evt` is high for exactly the cycle in which the lock bits of `ext_status` take a value that differs from their previous value. Reset leaves every lock bit at zero.
- R3: A high `src_slip[i]` sets `ext_status[16+i]`. The bit then stays set until a clearing read.
- R4: A cycle with `rd_stb`=1 and `rd_quad`=1 still shows the old slip bits. On the next edge every slip bit clears, except a bit that is pulsed in that same cycle.
- R5: A read with `rd_stb`=1 and `rd_quad`=0 (a block read) leaves all slip bits unchanged.
- R6: A slip pulse in the same cycle as a clearing read leaves that slip bit set after the edge.
- R7: Slip pulses and slip clears never raise `ext_evt` or `lock_evt`.
- R8: `cur_status[0]` shows, one edge after sampling, the lock input of the source chosen by `sel_src`. The codes are 0 to 3 for AES1 to AES4, 5 for ADAT, 6 for TDIF, 7 for word clock, and 8 to 11 for ARX1 to ARX4.
- R9: Code 0x0C (internal) always reads as locked. Code 0x04 (any AES) reads as locked when any of lock bits 3:0 is set. Every other code reads as unlocked.
- R10: `cur_status[15:8]` equals `rate_code` one edge after sampling (0 to 6 for 32 to 192 kHz, 0x0A for none). All bits of both words that are not defined above read as zero.
- R11: `lock_evt` is high for exactly the cycle in which `cur_status[0]` differs from its previous value. This includes changes caused by a new `sel_src`.
- R12: While `rst_n` is low at a clock edge, both status words and both event outputs become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lock | input | 11 | Live lock level per source |
| src_slip | input | 11 | Slip error pulse per source |
| sel_src | input | 8 | Selected clock source code |
| rate_code | input | 8 | Nominal rate code |
| rd_stb | input | 1 | Read of the extended status word in this cycle |
| rd_quad | input | 1 | 1: single-quadlet read, 0: block read |
| ext_status | output | 32 | Lock bits 10:0, slip bits 26:16 |
| cur_status | output | 32 | Selected-source lock bit 0, rate bits 15:8 |
| ext_evt | output | 1 | Pulse on any lock-bit change |
| lock_evt | output | 1 | Pulse on a selected-source lock change |

## Verification
The properties assume that every input is synchronous to `clk` and holds steady around each edge. They also assume that `rd_quad` matters only while `rd_stb` is high, and that the lock inputs arrive already synchronized, with no metastable values. The bench drives every input on the falling edge and samples the outputs just after the rising edge. It sweeps all sixteen low selection codes against empty, one-hot and full lock patterns, and walks each slip bit through pulses, block reads, quadlet reads and a pulse that coincides with a quadlet read.

// File: rtl/clkmon_pkg.sv
// Package: shared constants and the source code encoding for the clock monitor.
// Assumes the source order of the lock and slip fields is fixed by the host view.
package clkmon_pkg;
    localparam int NUM_SRC  = 11;
    localparam int CODE_W   = 8;
    localparam int SLIP_LSB = 16;
    localparam int WORD_W   = 32;

    // Bit position of each source inside the lock and slip fields
    localparam int BIT_AES1 = 0;
    localparam int BIT_ADAT = 4;
    localparam int BIT_TDIF = 5;
    localparam int BIT_ARX1 = 6;
    localparam int BIT_WCLK = 10;

    typedef enum logic [CODE_W-1:0] {
        SEL_AES1 = 8'h00, SEL_AES2 = 8'h01, SEL_AES3 = 8'h02, SEL_AES4 = 8'h03,
        SEL_AES_ANY = 8'h04, SEL_ADAT = 8'h05, SEL_TDIF = 8'h06, SEL_WCLK = 8'h07,
        SEL_ARX1 = 8'h08, SEL_ARX2 = 8'h09, SEL_ARX3 = 8'h0A, SEL_ARX4 = 8'h0B,
        SEL_INTERNAL = 8'h0C
    } sel_code_e;
endpackage

// File: rtl/clkmon_src_select.sv
// Module: maps the selection code to the lock level of that source.
// Assumes lock_in is synchronized; codes without a source read as unlocked.
module clkmon_src_select
    import clkmon_pkg::*;
(
    input  logic [NUM_SRC-1:0] lock_in,
    input  logic [CODE_W-1:0]  sel_code,
    output logic               sel_locked
);
    // Decode the selection code into one lock level
    always_comb begin
        sel_locked = 1'b0;
        if (sel_code < CODE_W'(4)) begin
            sel_locked = lock_in[BIT_AES1 + int'(sel_code[1:0])];
        end else if (sel_code >= CODE_W'(SEL_ARX1) && sel_code <= CODE_W'(SEL_ARX4)) begin
            sel_locked = lock_in[BIT_ARX1 + int'(sel_code[1:0])];
        end else begin
            case (sel_code)
                SEL_AES_ANY:  sel_locked = |lock_in[BIT_AES1 +: 4];
                SEL_ADAT:     sel_locked = lock_in[BIT_ADAT];
                SEL_TDIF:     sel_locked = lock_in[BIT_TDIF];
                SEL_WCLK:     sel_locked = lock_in[BIT_WCLK];
                SEL_INTERNAL: sel_locked = 1'b1;
                default:      sel_locked = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/clkmon_lock_track.sv
// Module: registers the live lock levels and flags any change as an event.
// Assumes inputs are synchronous; reset state is all unlocked.
module clkmon_lock_track #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lock_in,
    output logic [N-1:0] lock_q,
    output logic         chg_evt
);
    // Capture lock levels and pulse when they move
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= '0;
            chg_evt <= 1'b0;
        end else begin
            lock_q  <= lock_in;
            chg_evt <= (lock_in != lock_q);
        end
    end
endmodule

// File: rtl/clkmon_slip_sticky.sv
// Module: one sticky flag per source, set by pulses, cleared by a clearing read.
// Assumes a set pulse wins over a clear in the same cycle.
module clkmon_slip_sticky #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_in,
    input  logic         clr,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold the flag until cleared, with set taking priority
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_in[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr) begin
                flag_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/clksrc_lock_monitor.sv
// Module: top of the clock source monitor; builds the extended and current
// status words and the two notification pulses.
// Assumes all inputs are synchronous to clk and rd_quad is valid with rd_stb.
module clksrc_lock_monitor
    import clkmon_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_lock,
    input  logic [NUM_SRC-1:0]   src_slip,
    input  logic [CODE_W-1:0]    sel_src,
    input  logic [CODE_W-1:0]    rate_code,
    input  logic                 rd_stb,
    input  logic                 rd_quad,
    output logic [WORD_W-1:0]    ext_status,
    output logic [WORD_W-1:0]    cur_status,
    output logic                 ext_evt,
    output logic                 lock_evt
);
    localparam int RATE_LSB = 8;

    logic [NUM_SRC-1:0] lock_q;
    logic [NUM_SRC-1:0] slip_q;
    logic               sel_locked;
    logic               cur_lock_q;
    logic [CODE_W-1:0]  rate_q;
    logic               quad_clr;

    assign quad_clr = rd_stb & rd_quad;

    clkmon_lock_track #(.N(NUM_SRC)) u_lock (
        .clk(clk), .rst_n(rst_n), .lock_in(src_lock),
        .lock_q(lock_q), .chg_evt(ext_evt)
    );

    clkmon_slip_sticky #(.N(NUM_SRC)) u_slip (
        .clk(clk), .rst_n(rst_n), .set_in(src_slip),
        .clr(quad_clr), .flag_q(slip_q)
    );

    clkmon_src_select u_sel (
        .lock_in(src_lock), .sel_code(sel_src), .sel_locked(sel_locked)
    );

    // Register the selected lock state, its change pulse and the rate code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lock_q <= 1'b0;
            lock_evt   <= 1'b0;
            rate_q     <= '0;
        end else begin
            cur_lock_q <= sel_locked;
            lock_evt   <= (sel_locked != cur_lock_q);
            rate_q     <= rate_code;
        end
    end

    // Assemble the two host-visible status words
    always_comb begin
        ext_status = '0;
        ext_status[NUM_SRC-1:0] = lock_q;
        ext_status[SLIP_LSB +: NUM_SRC] = slip_q;
        cur_status = '0;
        cur_status[0] = cur_lock_q;
        cur_status[RATE_LSB +: CODE_W] = rate_q;
    end
endmodule

// File: rtl/clkmon_checker.sv
// Module: temporal checks on the monitor's ports, bound to the top module.
// Assumes synchronous inputs; every property is disabled during reset.
module clkmon_checker
    import clkmon_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_lock,
    input logic [NUM_SRC-1:0] src_slip,
    input logic [CODE_W-1:0]  sel_src,
    input logic [CODE_W-1:0]  rate_code,
    input logic               rd_stb,
    input logic               rd_quad,
    input logic [WORD_W-1:0]  ext_status,
    input logic [WORD_W-1:0]  cur_status,
    input logic               ext_evt,
    input logic               lock_evt
);
    p_lock_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ext_status[NUM_SRC-1:0] == $past(src_lock));

    p_lock_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_lock != ext_status[NUM_SRC-1:0]) |=> ext_evt);

    p_slip_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && rd_quad) |=>
        ((ext_status[SLIP_LSB +: NUM_SRC] & $past(ext_status[SLIP_LSB +: NUM_SRC]))
            == $past(ext_status[SLIP_LSB +: NUM_SRC])));

    p_quad_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_quad) |=> ext_status[SLIP_LSB +: NUM_SRC] == $past(src_slip));

    p_slip_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((ext_status[SLIP_LSB +: NUM_SRC] & $past(src_slip)) == $past(src_slip)));

    p_no_slip_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_lock == ext_status[NUM_SRC-1:0]) |=> !ext_evt);

    p_internal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_src == CODE_W'(SEL_INTERNAL)) |=> cur_status[0]);

    p_rate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cur_status[15:8] == $past(rate_code));

    p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cur_status[31:16] == '0) && (cur_status[7:1] == '0)
                  && (ext_status[15:NUM_SRC] == '0) && (ext_status[31:SLIP_LSB+NUM_SRC] == '0));

    p_sel_evt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_evt |-> $past(rst_n) && (cur_status[0] != $past(cur_status[0])));
endmodule

bind clksrc_lock_monitor clkmon_checker u_chk (
    .clk(clk), .rst_n(rst_n), .src_lock(src_lock), .src_slip(src_slip),
    .sel_src(sel_src), .rate_code(rate_code), .rd_stb(rd_stb), .rd_quad(rd_quad),
    .ext_status(ext_status), .cur_status(cur_status),
    .ext_evt(ext_evt), .lock_evt(lock_evt)
);

// File: tb/sim_clksrc_lock_monitor.sv
// Bench: sweeps lock patterns, selection codes, slip and read sequences, and
// compares every output after each edge with a model built from the requirements.
module sim_clksrc_lock_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;
    localparam int N          = 11;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [N-1:0] src_lock, src_slip;
    logic [7:0]  sel_src, rate_code;
    logic        rd_stb, rd_quad;
    logic [31:0] ext_status, cur_status;
    logic        ext_evt, lock_evt;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // Expected state
    logic [N-1:0] e_lock, e_slip;
    logic         e_cur, e_xevt, e_levt;
    logic [7:0]   e_rate;

    always #(CLK_PERIOD/2) clk = ~clk;

    clksrc_lock_monitor u0 (
        .clk(clk), .rst_n(rst_n), .src_lock(src_lock), .src_slip(src_slip),
        .sel_src(sel_src), .rate_code(rate_code), .rd_stb(rd_stb), .rd_quad(rd_quad),
        .ext_status(ext_status), .cur_status(cur_status),
        .ext_evt(ext_evt), .lock_evt(lock_evt)
    );

    // Selected-source lock per R8 and R9
    function automatic logic exp_sel(input logic [7:0] code, input logic [N-1:0] lk);
        case (code)
            8'h00: return lk[0];
            8'h01: return lk[1];
            8'h02: return lk[2];
            8'h03: return lk[3];
            8'h04: return |lk[3:0];
            8'h05: return lk[4];
            8'h06: return lk[5];
            8'h07: return lk[10];
            8'h08: return lk[6];
            8'h09: return lk[7];
            8'h0A: return lk[8];
            8'h0B: return lk[9];
            8'h0C: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply current inputs for one edge, advance the model, compare all outputs
    task automatic step(input string tag);
        logic nxt_cur;
        @(posedge clk);
        if (!rst_n) begin
            e_lock = '0; e_slip = '0; e_cur = 1'b0;
            e_xevt = 1'b0; e_levt = 1'b0; e_rate = '0;
        end else begin
            e_xevt  = (src_lock != e_lock);
            e_lock  = src_lock;
            e_slip  = (rd_stb && rd_quad) ? src_slip : (e_slip | src_slip);
            nxt_cur = exp_sel(sel_src, src_lock);
            e_levt  = (nxt_cur != e_cur);
            e_cur   = nxt_cur;
            e_rate  = rate_code;
        end
        #1;
        cmp({tag, " R1 lock field"}, {21'b0, ext_status[N-1:0]}, {21'b0, e_lock});
        cmp({tag, " R3 slip field"}, {21'b0, ext_status[16 +: N]}, {21'b0, e_slip});
        cmp({tag, " R10 spare ext bits"}, {ext_status[31:27], ext_status[15:11]}, '0);
        cmp({tag, " R2 ext event"}, {31'b0, ext_evt}, {31'b0, e_xevt});
        cmp({tag, " R8 current word"}, cur_status, {16'b0, e_rate, 7'b0, e_cur});
        cmp({tag, " R11 lock event"}, {31'b0, lock_evt}, {31'b0, e_levt});
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0; src_lock = '1; src_slip = '1; sel_src = 8'h0C;
        rate_code = 8'h06; rd_stb = 1'b0; rd_quad = 1'b0;
        @(negedge clk);
        // R12: reset clears everything even with active inputs
        for (int k = 0; k < 3; k++) step("R12 reset");
        rst_n = 1'b1; src_lock = '0; src_slip = '0; rate_code = 8'h0A;
        step("R12 release");

        // R1 R2: walk a single lock bit, then all, then none
        for (int b = 0; b < N; b++) begin
            src_lock = N'(1) << b;
            step("R1 walk");
            step("R2 hold");
        end
        src_lock = '1; step("R2 all");
        src_lock = '0; step("R2 none");

        // R8 R9 R11: every low code against empty, one-hot and full patterns
        for (int c = 0; c < 16; c++) begin
            sel_src = 8'(c);
            src_lock = '0; step("R9 code empty");
            for (int b = 0; b < N; b++) begin
                src_lock = N'(1) << b; step("R8 code onehot");
            end
            src_lock = '1; step("R9 code full");
        end
        sel_src = 8'hFF; src_lock = '1; step("R9 high code");
        src_lock = '0; step("R9 high code");

        // R3 R4 R5 R6 R7: per-bit slip sequences with locks held steady
        sel_src = 8'h00; src_lock = 11'h001;
        step("R7 settle");
        for (int b = 0; b < N; b++) begin
            src_slip = N'(1) << b; step("R3 set");
            src_slip = '0;         step("R7 hold");
            rd_stb = 1'b1; rd_quad = 1'b0; step("R5 block read");
            rd_stb = 1'b0;                 step("R5 after block");
            rd_stb = 1'b1; rd_quad = 1'b1; step("R4 quad read");
            rd_stb = 1'b0; rd_quad = 1'b0; step("R4 cleared");
            src_slip = N'(1) << b; rd_stb = 1'b1; rd_quad = 1'b1;
            step("R6 pulse with clear");
            src_slip = '0; rd_stb = 1'b0; rd_quad = 1'b0;
            step("R6 kept");
        end
        src_slip = '1; step("R3 all");
        src_slip = '0; rd_quad = 1'b1; step("R4 quad idle strobe low");
        rd_stb = 1'b1; step("R4 clear all");
        rd_stb = 1'b0; rd_quad = 1'b0; step("R4 empty");

        // R10: every nominal rate code plus an odd value
        for (int r = 0; r < 7; r++) begin
            rate_code = 8'(r); step("R10 rate");
        end
        rate_code = 8'h0A; step("R10 none");
        rate_code = 8'hFF; step("R10 wide");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule